// File: doc/BRIEF.md
# Pipelined Converter Digital Back End

This block sits behind the five quantizer stages of a pipelined analog-to-digital converter. Each stage delivers its coarse code for one input sample one clock after the stage in front of it. The block delays the early codes so that the five codes of one sample meet in the same cycle. It then adds them with one bit of overlap between neighbouring stages, so that decision errors in the first four stages cancel. Next it subtracts a per-stage error term for each stage, looked up by that stage's code in a small calibration store. It clips the result to the output range and registers a 14-bit word together with an out-of-range flag and a valid strobe.

A calibration sequencer outside the block loads the error terms through a simple write port while the calibration-mode input is high. During normal conversion the store is only read, and all five stages are looked up in the same cycle.

Top module: `adc_pipe_corr`

## Requirements
- R1: The codes of one sample are combined together when the stage-1 code arrives with `s_vld` high in some cycle and stage k's code (k = 1..5) is presented k-1 cycles later. `lead_code[k-1]` carries stage k for k = 1..4, and `tail_code` carries stage 5.
- R2: With all error terms zero, the word is the overlap sum stage1·1024 + stage2·128 + stage3·16 + stage4·2 + stage5. Each 4-bit lead code overlaps the top bit of the next stage by one bit.
- R3: Each stage's error term is read at address {stage index, code} and subtracted from the overlap sum. The terms are 8-bit two's complement values in output LSBs.
- R4: A corrected value above 16383 gives the word 16383 (all ones) with `out_otr` = 1.
- R5: A corrected value below 0 gives the word 0 with `out_otr` = 1. An in-range value gives `out_otr` = 0.
- R6: The word and `out_vld` for a sample appear 6 rising edges after the edge that samples its stage-1 code. `out_vld` is low in every cycle that does not carry a sample.
- R7: A write takes place on a clock edge where both `cal_we` and `cal_mode` are high. Address bits [6:4] select the stage (0 is stage 1, 4 is stage 5) and bits [3:0] select the code.
- R8: A write is ignored while `cal_mode` is low, and it is ignored when the stage field is 5 or more.
- R9: A synchronous active-low reset clears the alignment registers, the outputs, `out_vld` and every error term. A sample in flight when reset is asserted never produces a valid word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| s_vld | input | 1 | Stage-1 code in this cycle belongs to a new sample |
| lead_code | input | 16 | Codes of stages 1..4, four bits each, stage 1 in [3:0] |
| tail_code | input | 2 | Code of stage 5 |
| cal_mode | input | 1 | Calibration mode, enables error-term writes |
| cal_we | input | 1 | Error-term write strobe |
| cal_addr | input | 7 | Stage index [6:4] and code [3:0] of the term to write |
| cal_wdata | input | 8 | Error term, two's complement |
| out_word | output | 14 | Corrected, clipped output word |
| out_otr | output | 1 | Out-of-range flag for `out_word` |
| out_vld | output | 1 | Output word is valid |

## Verification
Suppose one lane of the skew registers has the wrong depth. Each sample's word then picks up a code from a neighbouring sample, so a stream of differing samples shows wrong words within six cycles of the first valid output. A bad error-term address or a write-gating fault shows only when a sample whose code hits that entry reaches the output, six cycles after it enters. The bench therefore writes terms and then runs samples that address them. A clipping fault shows in the same cycle as an overflowing or underflowing sample, either as a wrapped word or as a missing flag.

// File: rtl/adc_be_pkg.sv
// Package: shared defaults and the overlap weight rule of the back end.
// Assumes stages 1..NSTG-1 have equal code width and the last stage is narrower.
package adc_be_pkg;
    localparam int DEF_NSTG   = 5;
    localparam int DEF_CODE_W = 4;
    localparam int DEF_LAST_W = 2;
    localparam int DEF_ERR_W  = 8;

    // Left shift of lead stage k (0 = stage 1) so its LSB meets the next stage's MSB.
    function automatic int lead_shift(input int k, input int nstg,
                                      input int code_w, input int last_w);
        return (nstg - 2 - k) * (code_w - 1) + (last_w - 1);
    endfunction
endpackage

// File: rtl/skew_align.sv
// Module: skew_align
// Delays each stage's code by a depth that falls by one per stage, so the
// five codes of one sample leave together. Assumes stage k+1 delivers its
// code exactly one cycle after stage k for the same sample.
module skew_align #(
    parameter int NSTG   = 5,
    parameter int CODE_W = 4,
    parameter int LAST_W = 2
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           s_vld,
    input  logic [NSTG-2:0][CODE_W-1:0]    lead_code,
    input  logic [LAST_W-1:0]              tail_code,
    output logic [NSTG-2:0][CODE_W-1:0]    al_lead,
    output logic [LAST_W-1:0]              al_tail,
    output logic                           al_vld
);
    logic [NSTG-1:0] vsh;
    logic [LAST_W-1:0] tail_q;

    for (genvar k = 0; k < NSTG - 1; k++) begin : g_lane
        localparam int D = NSTG - k;
        logic [D-1:0][CODE_W-1:0] sh;

        // Shift chain for lead stage k.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                sh <= '0;
            end else begin
                sh[0] <= lead_code[k];
                for (int j = 1; j < D; j++) sh[j] <= sh[j-1];
            end
        end
        assign al_lead[k] = sh[D-1];
    end

    // Last stage arrives last and needs a single register.
    always_ff @(posedge clk) begin
        if (!rst_n) tail_q <= '0;
        else        tail_q <= tail_code;
    end
    assign al_tail = tail_q;

    // Sample marker travels with the stage-1 code.
    always_ff @(posedge clk) begin
        if (!rst_n) vsh <= '0;
        else        vsh <= {vsh[NSTG-2:0], s_vld};
    end
    assign al_vld = vsh[NSTG-1];

    AST_RST_CLEAR: assert property (@(posedge clk) !rst_n |=> (al_vld == 1'b0 && al_lead == '0)); // R9
endmodule

// File: rtl/cal_store.sv
// Module: cal_store
// Register-based store of per-stage error terms, one entry per stage and code.
// A gated write port is used by the calibration sequencer, and one combinational
// read port per stage is used during conversion. Reset clears every entry.
module cal_store #(
    parameter  int NSTG   = 5,
    parameter  int CODE_W = 4,
    parameter  int ERR_W  = 8,
    localparam int SEL_W  = $clog2(NSTG),
    localparam int AW     = SEL_W + CODE_W,
    localparam int DEPTH  = NSTG << CODE_W
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          cal_mode,
    input  logic                          cal_we,
    input  logic [AW-1:0]                 cal_addr,
    input  logic [ERR_W-1:0]              cal_wdata,
    input  logic [NSTG-1:0][CODE_W-1:0]   rd_code,
    output logic [NSTG-1:0][ERR_W-1:0]    rd_err
);
    logic [DEPTH-1:0][ERR_W-1:0] mem;
    logic wr_ok;

    // Stage field must name an existing stage.
    assign wr_ok = (int'(cal_addr[AW-1:CODE_W]) < NSTG);

    // Gated write, full clear on reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mem <= '0;
        end else if (cal_mode && cal_we && wr_ok) begin
            mem[cal_addr] <= cal_wdata;
        end
    end

    for (genvar k = 0; k < NSTG; k++) begin : g_rd
        localparam logic [SEL_W-1:0] KSEL = SEL_W'(k);
        assign rd_err[k] = mem[{KSEL, rd_code[k]}];
    end

    AST_WR_BLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        !cal_mode |=> $stable(mem)); // R8
    AST_WR_TAKE: assert property (@(posedge clk) disable iff (!rst_n)
        (cal_mode && cal_we && wr_ok) |=> mem[$past(cal_addr)] == $past(cal_wdata)); // R7
endmodule

// File: rtl/overlap_sum.sv
// Module: overlap_sum
// Adds aligned stage codes with one bit of overlap and totals the signed
// error terms; both results are registered together with the sample marker.
// Assumes error terms are already scaled to output LSBs.
module overlap_sum #(
    parameter  int NSTG   = 5,
    parameter  int CODE_W = 4,
    parameter  int LAST_W = 2,
    parameter  int ERR_W  = 8,
    localparam int OUT_W  = (NSTG - 1) * (CODE_W - 1) + LAST_W,
    localparam int SUM_W  = OUT_W + 2,
    localparam int ES_W   = ERR_W + $clog2(NSTG) + 1
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [NSTG-2:0][CODE_W-1:0]   al_lead,
    input  logic [LAST_W-1:0]             al_tail,
    input  logic                          al_vld,
    input  logic [NSTG-1:0][ERR_W-1:0]    err,
    output logic [SUM_W-1:0]              raw_q,
    output logic signed [ES_W-1:0]        err_q,
    output logic                          sum_vld
);
    logic [SUM_W-1:0]       raw_c;
    logic signed [ES_W-1:0] err_c;

    // Weighted overlap addition of all stage codes.
    always_comb begin
        raw_c = SUM_W'(al_tail);
        for (int k = 0; k < NSTG - 1; k++) begin
            raw_c = raw_c + (SUM_W'(al_lead[k]) << adc_be_pkg::lead_shift(k, NSTG, CODE_W, LAST_W));
        end
    end

    // Sign-extended total of the looked-up error terms.
    always_comb begin
        err_c = '0;
        for (int k = 0; k < NSTG; k++) begin
            err_c = err_c + ES_W'($signed(err[k]));
        end
    end

    // Register sums and marker.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            raw_q   <= '0;
            err_q   <= '0;
            sum_vld <= 1'b0;
        end else begin
            raw_q   <= raw_c;
            err_q   <= err_c;
            sum_vld <= al_vld;
        end
    end
endmodule

// File: rtl/adc_pipe_corr.sv
// Module: adc_pipe_corr (top)
// Digital back end of a five-stage pipelined converter: aligns skewed stage
// codes, adds them with overlap, subtracts stored error terms, clips to the
// output range and registers word, out-of-range flag and valid.
// Assumes the calibration store is written only while conversions are idle.
module adc_pipe_corr #(
    parameter  int NSTG   = adc_be_pkg::DEF_NSTG,
    parameter  int CODE_W = adc_be_pkg::DEF_CODE_W,
    parameter  int LAST_W = adc_be_pkg::DEF_LAST_W,
    parameter  int ERR_W  = adc_be_pkg::DEF_ERR_W,
    localparam int OUT_W  = (NSTG - 1) * (CODE_W - 1) + LAST_W,
    localparam int AW     = $clog2(NSTG) + CODE_W
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         s_vld,
    input  logic [NSTG-2:0][CODE_W-1:0]  lead_code,
    input  logic [LAST_W-1:0]            tail_code,
    input  logic                         cal_mode,
    input  logic                         cal_we,
    input  logic [AW-1:0]                cal_addr,
    input  logic [ERR_W-1:0]             cal_wdata,
    output logic [OUT_W-1:0]             out_word,
    output logic                         out_otr,
    output logic                         out_vld
);
    localparam int SUM_W = OUT_W + 2;
    localparam int ES_W  = ERR_W + $clog2(NSTG) + 1;
    localparam int CW    = SUM_W + 2;
    localparam logic signed [CW-1:0] HI_LIM = CW'((1 << OUT_W) - 1);

    logic [NSTG-2:0][CODE_W-1:0] al_lead;
    logic [LAST_W-1:0]           al_tail;
    logic                        al_vld;
    logic [NSTG-1:0][CODE_W-1:0] rd_code;
    logic [NSTG-1:0][ERR_W-1:0]  rd_err;
    logic [SUM_W-1:0]            raw_q;
    logic signed [ES_W-1:0]      err_q;
    logic                        sum_vld;
    logic signed [CW-1:0]        corr;
    logic [OUT_W-1:0]            word_c;
    logic                        otr_c;

    skew_align #(.NSTG(NSTG), .CODE_W(CODE_W), .LAST_W(LAST_W)) u_align (
        .clk(clk), .rst_n(rst_n), .s_vld(s_vld),
        .lead_code(lead_code), .tail_code(tail_code),
        .al_lead(al_lead), .al_tail(al_tail), .al_vld(al_vld)
    );

    // Lookup addresses: lead codes as is, last code zero-extended.
    always_comb begin
        for (int k = 0; k < NSTG - 1; k++) rd_code[k] = al_lead[k];
        rd_code[NSTG-1] = CODE_W'(al_tail);
    end

    cal_store #(.NSTG(NSTG), .CODE_W(CODE_W), .ERR_W(ERR_W)) u_store (
        .clk(clk), .rst_n(rst_n), .cal_mode(cal_mode), .cal_we(cal_we),
        .cal_addr(cal_addr), .cal_wdata(cal_wdata),
        .rd_code(rd_code), .rd_err(rd_err)
    );

    overlap_sum #(.NSTG(NSTG), .CODE_W(CODE_W), .LAST_W(LAST_W), .ERR_W(ERR_W)) u_sum (
        .clk(clk), .rst_n(rst_n), .al_lead(al_lead), .al_tail(al_tail),
        .al_vld(al_vld), .err(rd_err),
        .raw_q(raw_q), .err_q(err_q), .sum_vld(sum_vld)
    );

    // Apply correction and clip to the output rails.
    always_comb begin
        corr = $signed({2'b00, raw_q}) - CW'(err_q);
        if (corr < 0) begin
            word_c = '0;
            otr_c  = 1'b1;
        end else if (corr > HI_LIM) begin
            word_c = '1;
            otr_c  = 1'b1;
        end else begin
            word_c = corr[OUT_W-1:0];
            otr_c  = 1'b0;
        end
    end

    // Output register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_word <= '0;
            out_otr  <= 1'b0;
            out_vld  <= 1'b0;
        end else begin
            out_word <= word_c;
            out_otr  <= otr_c;
            out_vld  <= sum_vld;
        end
    end

    AST_CLIP_RAIL: assert property (@(posedge clk) disable iff (!rst_n)
        out_otr |-> (out_word == '1 || out_word == '0)); // R4, R5
    AST_OUT_RST: assert property (@(posedge clk) !rst_n |=> (!out_vld && !out_otr)); // R9
endmodule

// File: tb/sim_adc_pipe_corr.sv
`timescale 1ns/1ps
module sim_adc_pipe_corr;
    typedef struct packed {
        logic [3:0]  c1, c2, c3, c4;
        logic [1:0]  c5;
        logic [13:0] w;
        logic        o;
    } vec_t;

    localparam int NV = 9;
    localparam vec_t TAB [NV] = '{
        '{4'd0,  4'd0,  4'd0,  4'd0,  2'd0, 14'd0,     1'b0},
        '{4'd1,  4'd0,  4'd0,  4'd0,  2'd0, 14'd1024,  1'b0},
        '{4'd8,  4'd8,  4'd8,  4'd8,  2'd2, 14'd9362,  1'b0},
        '{4'd15, 4'd15, 4'd15, 4'd15, 2'd3, 14'd16383, 1'b1},
        '{4'd15, 4'd15, 4'd15, 4'd15, 2'd0, 14'd16383, 1'b1},
        '{4'd0,  4'd0,  4'd0,  4'd0,  2'd3, 14'd3,     1'b0},
        '{4'd5,  4'd3,  4'd9,  4'd2,  2'd1, 14'd5653,  1'b0},
        '{4'd15, 4'd7,  4'd7,  4'd7,  2'd1, 14'd16383, 1'b0},
        '{4'd15, 4'd7,  4'd7,  4'd7,  2'd2, 14'd16383, 1'b1}
    };

    logic              clk = 1'b0;
    logic              rst_n;
    logic              s_vld;
    logic [3:0][3:0]   lead_code;
    logic [1:0]        tail_code;
    logic              cal_mode, cal_we;
    logic [6:0]        cal_addr;
    logic [7:0]        cal_wdata;
    logic [13:0]       out_word;
    logic              out_otr, out_vld;
    int total = 0;
    int bad = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    adc_pipe_corr u0 (
        .clk(clk), .rst_n(rst_n), .s_vld(s_vld), .lead_code(lead_code),
        .tail_code(tail_code), .cal_mode(cal_mode), .cal_we(cal_we),
        .cal_addr(cal_addr), .cal_wdata(cal_wdata),
        .out_word(out_word), .out_otr(out_otr), .out_vld(out_vld)
    );

    task automatic chk(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s act=%0d exp=%0d", req, act, exp);
        end
    endtask

    function automatic logic [3:0] lead_of(input vec_t v, input int k);
        case (k)
            0: return v.c1;
            1: return v.c2;
            2: return v.c3;
            default: return v.c4;
        endcase
    endfunction

    task automatic idle_inputs();
        s_vld = 1'b0; lead_code = '0; tail_code = '0;
    endtask

    task automatic wr_term(input logic mode, input logic [6:0] a, input logic [7:0] d);
        @(negedge clk);
        cal_mode = mode; cal_we = 1'b1; cal_addr = a; cal_wdata = d;
        @(negedge clk);
        cal_we = 1'b0; cal_mode = 1'b0;
    endtask

    // Feed one sample with skewed stage codes and check it 6 edges later.
    task automatic run_one(input vec_t v, input string req);
        for (int t = 0; t < 9; t++) begin
            @(negedge clk);
            if (t == 6) chk({req, " vld early"}, out_vld, 0);
            if (t == 7) begin
                chk({req, " vld"}, out_vld, 1);
                chk({req, " word"}, out_word, v.w);
                chk({req, " otr"}, out_otr, v.o);
            end
            idle_inputs();
            s_vld = (t == 0);
            for (int k = 0; k < 4; k++) if (t == k) lead_code[k] = lead_of(v, k);
            if (t == 4) tail_code = v.c5;
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            total++; bad++;
            $display("FAIL R6 watchdog act=hung exp=done");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        vec_t v;
        bit seen;
        rst_n = 1'b0; cal_mode = 1'b0; cal_we = 1'b0; cal_addr = '0; cal_wdata = '0;
        idle_inputs();
        repeat (3) @(negedge clk);
        // R9: reset state
        chk("R9 rst vld", out_vld, 0);
        chk("R9 rst word", out_word, 0);
        chk("R9 rst otr", out_otr, 0);
        rst_n = 1'b1;

        // R1 R2 R4 R5 R6: back-to-back stream of table samples
        for (int t = 0; t < NV + 9; t++) begin
            @(negedge clk);
            if (t - 7 >= 0 && t - 7 < NV) begin
                chk("R6 stream vld", out_vld, 1);
                chk("R1 R2 stream word", out_word, TAB[t-7].w);
                chk("R4 R5 stream otr", out_otr, TAB[t-7].o);
            end else begin
                chk("R6 stream bubble", out_vld, 0);
            end
            idle_inputs();
            s_vld = (t < NV);
            for (int k = 0; k < 4; k++)
                if (t - k >= 0 && t - k < NV) lead_code[k] = lead_of(TAB[t-k], k);
            if (t - 4 >= 0 && t - 4 < NV) tail_code = TAB[t-4].c5;
        end

        // R3 R7: stage1 code8 = +5, stage5 code2 = -3
        wr_term(1'b1, 7'h08, 8'd5);
        wr_term(1'b1, 7'h42, 8'hFD);
        v = TAB[2]; v.w = 14'd9360; v.o = 1'b0;
        run_one(v, "R3 R7 corrected");

        // R8: write with cal_mode low is ignored
        wr_term(1'b0, 7'h18, 8'd100);
        run_one(v, "R8 mode low");
        // R8: stage field 5 is ignored
        wr_term(1'b1, 7'h58, 8'd50);
        run_one(v, "R8 bad stage");

        // R5: stage1 code0 = +100 drives all-zero sample below zero
        wr_term(1'b1, 7'h00, 8'd100);
        v = TAB[0]; v.w = 14'd0; v.o = 1'b1;
        run_one(v, "R5 low clip");

        // R4: stage1 code15 = -1 pushes 16383 over the top
        wr_term(1'b1, 7'h0F, 8'hFF);
        v = TAB[7]; v.w = 14'd16383; v.o = 1'b1;
        run_one(v, "R4 high clip");

        // R9: reset while a sample is in flight
        seen = 1'b0;
        for (int t = 0; t < 12; t++) begin
            @(negedge clk);
            if (out_vld) seen = 1'b1;
            idle_inputs();
            s_vld = (t == 0);
            if (t == 0) lead_code[0] = 4'd8;
            rst_n = !(t == 2 || t == 3);
        end
        chk("R9 flight dropped", seen, 0);
        // R9: error terms cleared by reset
        run_one(TAB[2], "R9 terms cleared");

        finished = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule